// File: doc/BRIEF.md
# Asynchronous NOR Memory Access Sequencer

This block drives one bank of asynchronous NOR flash or SRAM-like memory. The memory has separate address and data buses. A host issues single read or write requests through a request/busy handshake. The sequencer then asserts chip select for a two-phase access: an address-setup phase followed by a data phase, both counted in system clock cycles. Read data comes back on a one-cycle done pulse, and the data is held until the next read finishes.

Each access takes its timing from a set of three programmable values: setup length, data length and turnaround gap. There are two such sets, one for reads and one for writes. The write set is used only for writes, and only while extended mode is on; otherwise writes use the read set. After each access, chip select stays high for the turnaround gap before the next access can begin. While the bank is disabled, no access starts.

Top module: `nor_seq`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are 1; busy, done and mem_dout_en are 0; rdata and mem_addr are 0.
- R2: A request is accepted on a clock edge where req=1, bank_en=1 and busy was 0. The address-setup phase then lasts exactly S cycles (chip select low, S taken from the setup field). S=0 is legal and skips the phase.
- R3: The data phase follows the setup phase and lasts max(D,1) cycles, where D is the data-length field. A value of 0 therefore gives one cycle.
- R4: After an access ends, chip select stays high for at least max(G,1) cycles, where G is the turnaround field of that access. When the next request is already waiting, it stays high for exactly max(G,1) cycles.
- R5: With ext_mode=1, writes use wr_setup/wr_dlen/wr_turn and reads use rd_setup/rd_dlen/rd_turn.
- R6: With ext_mode=0, the wr_* fields have no effect, and writes run with the read timing set.
- R7: While bank_en=0, req is ignored: chip select stays high and busy stays 0.
- R8: On a read, mem_oe_n is low for every cycle that chip select is low. On a write, mem_we_n is low only during the data phase. mem_oe_n and mem_we_n are never low together, and neither is low while chip select is high.
- R9: mem_addr and mem_dout take the request's addr and wdata at acceptance and hold them until the access ends. mem_dout_en is 1 exactly while chip select is low on a write.
- R10: On a read, mem_din is captured on the last cycle of the data phase. done pulses for one cycle in the first cycle after the access, with rdata holding the captured word. Writes also pulse done but leave rdata unchanged.
- R11: busy is 1 from the accepted access until the turnaround gap ends. A request held high while busy is accepted only after that.
- R12: The timing fields are sampled at acceptance. Changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_en | input | 1 | Bank enable; 0 blocks new accesses |
| ext_mode | input | 1 | 1 selects the separate write timing set for writes |
| rd_setup | input | SET_W | Read (or shared) address-setup length |
| rd_dlen | input | DST_W | Read (or shared) data-phase length |
| rd_turn | input | TURN_W | Read (or shared) turnaround gap |
| wr_setup | input | SET_W | Write address-setup length (extended mode) |
| wr_dlen | input | DST_W | Write data-phase length (extended mode) |
| wr_turn | input | TURN_W | Write turnaround gap (extended mode) |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Access address |
| wdata | input | DATA_W | Write data |
| busy | output | 1 | Access or turnaround in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last read word |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Write data to memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DATA_W | Read data from memory |

## Verification
The bench uses the default widths: 16-bit address and data, 4-bit setup and turnaround fields, and an 8-bit data-length field. With these widths it can reach the zero-length setup and data cases, the one-cycle clamp and the largest data length of 255. The modelled memory returns a word that changes every cycle. A wrong capture cycle therefore shows up in rdata, not just a wrong address.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_DATA  = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/nor_tim_sel.sv
// Picks the timing set for the incoming request and clamps the data phase.
module nor_tim_sel #(
  parameter int SET_W  = 4,
  parameter int DST_W  = 8,
  parameter int TURN_W = 4
) (
  input  logic              ext_mode,
  input  logic              is_write,
  input  logic [SET_W-1:0]  rd_setup,
  input  logic [DST_W-1:0]  rd_dlen,
  input  logic [TURN_W-1:0] rd_turn,
  input  logic [SET_W-1:0]  wr_setup,
  input  logic [DST_W-1:0]  wr_dlen,
  input  logic [TURN_W-1:0] wr_turn,
  output logic [SET_W-1:0]  sel_setup,
  output logic [DST_W-1:0]  sel_dlen,
  output logic [TURN_W-1:0] sel_turn
);
  logic             use_wr;
  logic [DST_W-1:0] raw_dlen;

  always_comb begin
    use_wr    = ext_mode && is_write;
    sel_setup = use_wr ? wr_setup : rd_setup;
    raw_dlen  = use_wr ? wr_dlen  : rd_dlen;
    sel_turn  = use_wr ? wr_turn  : rd_turn;
    sel_dlen  = (raw_dlen == '0) ? DST_W'(1) : raw_dlen;
  end
endmodule

// File: rtl/nor_phase_fsm.sv
// Phase sequencer: setup, data, turnaround, with a shared down-counter.
module nor_phase_fsm
  import nor_seq_pkg::*;
#(
  parameter int SET_W  = 4,
  parameter int DST_W  = 8,
  parameter int TURN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SET_W-1:0]  setup,
  input  logic [DST_W-1:0]  dlen,
  input  logic [TURN_W-1:0] turn,
  output seq_state_e        state,
  output seq_state_e        nxt_state,
  output logic              last_data
);
  localparam int W_ST  = (SET_W > TURN_W) ? SET_W : TURN_W;
  localparam int CNT_W = (DST_W > W_ST) ? DST_W : W_ST;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [DST_W-1:0]  dlen_q;
  logic [TURN_W-1:0] turn_q;

  assign last_data = (state == ST_DATA) && (cnt == '0);

  always_comb begin
    nxt_state = state;
    cnt_nxt   = cnt;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (setup != '0) begin
            nxt_state = ST_SETUP;
            cnt_nxt   = CNT_W'(setup) - ONE;
          end else begin
            nxt_state = ST_DATA;
            cnt_nxt   = CNT_W'(dlen) - ONE;
          end
        end
      end
      ST_SETUP: begin
        if (cnt == '0) begin
          nxt_state = ST_DATA;
          cnt_nxt   = CNT_W'(dlen_q) - ONE;
        end else begin
          cnt_nxt = cnt - ONE;
        end
      end
      ST_DATA: begin
        if (cnt == '0) begin
          if (turn_q > TURN_W'(1)) begin
            nxt_state = ST_GAP;
            cnt_nxt   = CNT_W'(turn_q) - TWO;
          end else begin
            nxt_state = ST_IDLE;
          end
        end else begin
          cnt_nxt = cnt - ONE;
        end
      end
      default: begin
        if (cnt == '0) nxt_state = ST_IDLE;
        else           cnt_nxt   = cnt - ONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      dlen_q <= '0;
      turn_q <= '0;
    end else begin
      state <= nxt_state;
      cnt   <= cnt_nxt;
      if (start && state == ST_IDLE) begin
        dlen_q <= dlen;
        turn_q <= turn;
      end
    end
  end
endmodule

// File: rtl/nor_seq.sv
// Top: host handshake, registered memory-side strobes and data path.
module nor_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SET_W  = 4,
  parameter int DST_W  = 8,
  parameter int TURN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_en,
  input  logic              ext_mode,
  input  logic [SET_W-1:0]  rd_setup,
  input  logic [DST_W-1:0]  rd_dlen,
  input  logic [TURN_W-1:0] rd_turn,
  input  logic [SET_W-1:0]  wr_setup,
  input  logic [DST_W-1:0]  wr_dlen,
  input  logic [TURN_W-1:0] wr_turn,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);
  logic [SET_W-1:0]  sel_setup;
  logic [DST_W-1:0]  sel_dlen;
  logic [TURN_W-1:0] sel_turn;
  seq_state_e        state, nxt_state;
  logic              last_data;
  logic              start, wr_q, wr_nxt, acc_nxt;

  assign start   = req && bank_en && (state == ST_IDLE);
  assign wr_nxt  = start ? we : wr_q;
  assign acc_nxt = (nxt_state == ST_SETUP) || (nxt_state == ST_DATA);

  nor_tim_sel #(.SET_W(SET_W), .DST_W(DST_W), .TURN_W(TURN_W)) u_sel (
    .ext_mode (ext_mode),
    .is_write (we),
    .rd_setup (rd_setup),
    .rd_dlen  (rd_dlen),
    .rd_turn  (rd_turn),
    .wr_setup (wr_setup),
    .wr_dlen  (wr_dlen),
    .wr_turn  (wr_turn),
    .sel_setup(sel_setup),
    .sel_dlen (sel_dlen),
    .sel_turn (sel_turn)
  );

  nor_phase_fsm #(.SET_W(SET_W), .DST_W(DST_W), .TURN_W(TURN_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .setup    (sel_setup),
    .dlen     (sel_dlen),
    .turn     (sel_turn),
    .state    (state),
    .nxt_state(nxt_state),
    .last_data(last_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q        <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      rdata       <= '0;
      mem_cs_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
    end else begin
      wr_q        <= wr_nxt;
      busy        <= (nxt_state != ST_IDLE);
      done        <= last_data;
      mem_cs_n    <= !acc_nxt;
      mem_oe_n    <= !(acc_nxt && !wr_nxt);
      mem_we_n    <= !((nxt_state == ST_DATA) && wr_nxt);
      mem_dout_en <= acc_nxt && wr_nxt;
      if (start) begin
        mem_addr <= addr;
        mem_dout <= wdata;
      end
      if (last_data && !wr_q) rdata <= mem_din;
    end
  end
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bank_en,
  input logic              busy,
  input logic              done,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_dout_en
);
  // R8
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R8
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n |-> (mem_oe_n && mem_we_n));

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

  // R9
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dout_en);

  // R10
  done_after_access_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_cs_n && $past(!mem_cs_n)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  bank_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !bank_en) |=> mem_cs_n);
endmodule

bind nor_seq nor_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bank_en    (bank_en),
  .busy       (busy),
  .done       (done),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_addr   (mem_addr),
  .mem_dout   (mem_dout),
  .mem_dout_en(mem_dout_en)
);

// File: tb/tb_nor_seq.sv
`timescale 1ns/1ps
module tb_nor_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_en = 1'b1, ext_mode = 1'b0;
  logic [3:0]  rd_setup = '0, wr_setup = '0, rd_turn = '0, wr_turn = '0;
  logic [7:0]  rd_dlen = '0, wr_dlen = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0, mem_din = '0;
  logic        busy, done, mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [15:0] rdata, mem_addr, mem_dout;

  always #5 clk = ~clk;

  nor_seq dut (
    .clk(clk), .rst(rst), .bank_en(bank_en), .ext_mode(ext_mode),
    .rd_setup(rd_setup), .rd_dlen(rd_dlen), .rd_turn(rd_turn),
    .wr_setup(wr_setup), .wr_dlen(wr_dlen), .wr_turn(wr_turn),
    .req(req), .we(we), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit finished = 0;

  // reference schedule of the current access
  int t_acc = -1000, t_last = -1000, a_set = 0, a_dat = 1, a_gap = 1;
  bit a_we = 0;
  logic [15:0] a_addr = '0, a_wdata = '0, exp_rdata = '0;

  function automatic logic [15:0] base_word(input logic [15:0] a);
    return a ^ 16'h5A5A;
  endfunction

  function automatic bit exp_busy(input int c);
    int g;
    g = (a_gap < 1) ? 1 : a_gap;
    return (c >= t_acc) && (c <= t_last + g - 1);
  endfunction

  task automatic cmp(input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, nm, cyc, act, exp);
    end
  endtask

  task automatic check_cycle(input int c);
    bit in_acc, in_dat;
    in_acc = (c >= t_acc) && (c <= t_last);
    in_dat = (c >= t_acc + a_set) && (c <= t_last);
    if (c == t_last + 1 && !a_we) exp_rdata = base_word(a_addr) + 16'(t_last);
    cmp("mem_cs_n", 32'(mem_cs_n), 32'(!in_acc));
    cmp("mem_oe_n", 32'(mem_oe_n), 32'(!(in_acc && !a_we)));
    cmp("mem_we_n", 32'(mem_we_n), 32'(!(in_dat && a_we)));
    cmp("mem_dout_en", 32'(mem_dout_en), 32'(in_acc && a_we));
    cmp("busy", 32'(busy), 32'(exp_busy(c)));
    cmp("done", 32'(done), 32'(c == t_last + 1));
    cmp("rdata", 32'(rdata), 32'(exp_rdata));
    if (in_acc) cmp("mem_addr", 32'(mem_addr), 32'(a_addr));
    if (in_acc && a_we) cmp("mem_dout", 32'(mem_dout), 32'(a_wdata));
  endtask

  // called at a falling edge; drives inputs, advances one cycle, checks
  task automatic step(input logic r, input logic w, input logic [15:0] a, input logic [15:0] d);
    req = r; we = w; addr = a; wdata = d;
    if (r && bank_en && !exp_busy(cyc)) begin
      bit uw;
      uw      = ext_mode && w;
      t_acc   = cyc + 1;
      a_we    = w;
      a_addr  = a;
      a_wdata = d;
      a_set   = int'(uw ? wr_setup : rd_setup);
      a_dat   = int'(uw ? wr_dlen : rd_dlen);
      if (a_dat == 0) a_dat = 1;
      a_gap   = int'(uw ? wr_turn : rd_turn);
      t_last  = t_acc + a_set + a_dat - 1;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check_cycle(cyc);
    mem_din = base_word(mem_addr) + 16'(cyc);
  endtask

  task automatic drain();
    while (exp_busy(cyc) || cyc <= t_last + 1) step(1'b0, 1'b0, 16'h0, 16'h0);
  endtask

  task automatic one(input logic w, input logic [15:0] a, input logic [15:0] d);
    step(1'b1, w, a, d);
    drain();
  endtask

  task automatic set_rd(input int s, input int dl, input int g);
    rd_setup = 4'(s); rd_dlen = 8'(dl); rd_turn = 4'(g);
  endtask

  task automatic set_wr(input int s, input int dl, input int g);
    wr_setup = 4'(s); wr_dlen = 8'(dl); wr_turn = 4'(g);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values, before any request
    tag = "R1";
    check_cycle(cyc);
    rst = 1'b0;
    step(1'b0, 1'b0, 16'h0, 16'h0);

    // R2: setup of zero and of three cycles
    tag = "R2";
    set_rd(0, 2, 0); one(1'b0, 16'h0011, 16'h0);
    set_rd(3, 2, 2); one(1'b0, 16'h0022, 16'h0);
    set_rd(15, 1, 1); one(1'b0, 16'h0023, 16'h0);

    // R3: data length 0 clamps to one cycle; longer phases
    tag = "R3";
    set_rd(1, 0, 1); one(1'b0, 16'h0033, 16'h0);
    set_rd(0, 5, 0); one(1'b0, 16'h0034, 16'h0);
    set_rd(0, 255, 0); one(1'b0, 16'h0035, 16'h0);

    // R4: turnaround with next request waiting
    tag = "R4";
    set_rd(1, 2, 5);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 16'(16'h0400 + i), 16'h0);
    set_rd(0, 1, 0);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 16'(16'h0480 + i), 16'h0);
    drain();

    // R5: extended mode uses write set for writes, read set for reads
    tag = "R5";
    ext_mode = 1'b1;
    set_rd(1, 1, 1); set_wr(2, 4, 3);
    one(1'b1, 16'h0555, 16'hBEEF);
    one(1'b0, 16'h0556, 16'h0);
    set_wr(0, 0, 0);
    one(1'b1, 16'h0557, 16'hCAFE);

    // R6: without extended mode the write set has no effect
    tag = "R6";
    ext_mode = 1'b0;
    set_rd(2, 3, 2); set_wr(9, 40, 7);
    one(1'b1, 16'h0666, 16'h1234);
    one(1'b1, 16'h0667, 16'h4321);

    // R7: bank disabled ignores requests
    tag = "R7";
    bank_en = 1'b0;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 16'h0777, 16'h0);
    bank_en = 1'b1;
    one(1'b0, 16'h0778, 16'h0);

    // R8: strobe shapes for reads and writes
    tag = "R8";
    set_rd(2, 3, 1);
    one(1'b0, 16'h0888, 16'h0);
    one(1'b1, 16'h0889, 16'h5555);

    // R9: buses held for the whole access
    tag = "R9";
    set_rd(4, 6, 2);
    one(1'b1, 16'h0999, 16'hA5A5);

    // R10: capture on last data cycle; write leaves rdata alone
    tag = "R10";
    set_rd(1, 6, 1);
    one(1'b0, 16'h0AAA, 16'h0);
    one(1'b1, 16'h0AAB, 16'h7777);

    // R11: request held while busy, changing address each cycle
    tag = "R11";
    set_rd(1, 2, 3);
    for (int i = 0; i < 40; i++) step(1'b1, i[0], 16'(16'h0B00 + i), 16'(16'hF000 + i));
    drain();

    // R12: timing inputs changed mid-access
    tag = "R12";
    set_rd(2, 4, 3);
    step(1'b1, 1'b0, 16'h0CCC, 16'h0);
    set_rd(9, 30, 9);
    step(1'b0, 1'b0, 16'h0, 16'h0);
    set_rd(0, 0, 0);
    drain();
    one(1'b0, 16'h0CCD, 16'h0);

    repeat (3) step(1'b0, 1'b0, 16'h0, 16'h0);
    summary();
    $finish;
  end
endmodule